// File: doc/BRIEF.md
# Two-stage decoded byte memory

A single-port static memory of bytes. It is not built as one flat array of words. Storage is split into 32 sub-arrays, and each sub-array holds rows that are 128 bits wide. The address is divided into three fields:

- A row field drives a one-hot row decoder. All sub-arrays share this decoder, so the same row is selected in each of them.
- A group field chooses one set of eight sub-arrays out of four such sets.
- A column field picks one bit out of the selected 128-bit row in each of the eight chosen sub-arrays. Sub-array k of the group gives data bit k.

Every selection is made with multiplexers, so there are no tri-state buses.

Writes are synchronous. Reads are combinational from the address. An output enable forces the data output to zero when it is low. The parameter `ROW_BITS` sets the number of rows in each sub-array. With `ROW_BITS = 11` the memory has 2048 rows, a 20-bit address and 1M bytes. Smaller values shrink only the row field. The group field, the column field and the 32 x 128-bit structure stay the same.

Top module: `sram_2stage`

## Requirements
- R1: When `we` is high at a rising clock edge, the byte on `din` is stored at `addr`. Later reads of that address with `oe` high return it.
- R2: A read has no latency. `dout` shows the stored byte of the address currently applied, in the same cycle, with no clock edge needed.
- R3: While `oe` is low, `dout` is 8'h00, whatever the address and the contents.
- R4: In the cycle of a write, a read of the same address returns the old contents. The new byte appears only after the edge.
- R5: Cycles with `we` low change no stored byte, whatever `din` carries.
- R6: A write changes only the addressed byte. Addresses that differ only in the column bits [6:0], only in the group bits [8:7], or only in the row bits keep their contents.
- R7: Address bits [6:0] are the column index, bits [8:7] are the group index and bits [ROW_BITS+8:9] are the row index. Every address in the space is a separate location.
- R8: The address is `ROW_BITS + 9` bits wide and reaches 2^ROW_BITS rows. The lowest address and the all-ones address are distinct locations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input  | 1 | Clock. Writes take effect on its rising edge |
| addr | input  | ROW_BITS+9 | Byte address: row, group and column fields |
| din  | input  | 8 | Byte to write |
| we   | input  | 1 | Write enable, sampled at the rising edge |
| oe   | input  | 1 | Output enable. When low, `dout` is zero |
| dout | output | 8 | Byte read from `addr`, or zero |

## Verification
The bench uses the default `ROW_BITS = 4`. That gives 16 rows and 8192 bytes, so one pass can write every address and read it back, and it covers each row, group and column combination. At this depth the all-ones address and the neighbours that differ in one field at a time are reached in a few thousand cycles. The full 2048-row build uses exactly the same column and group logic.

// File: rtl/sram_2stage.sv
module sram_2stage #(
  parameter int ROW_BITS = 4,
  localparam int AW = ROW_BITS + 9
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  input  logic          we,
  input  logic          oe,
  output logic [7:0]    dout
);
  localparam int COL_BITS = 7;
  localparam int GRP_BITS = 2;
  localparam int LANES    = 8;
  localparam int GROUPS   = 1 << GRP_BITS;
  localparam int SUBS     = GROUPS * LANES;
  localparam int ROW_W    = 1 << COL_BITS;
  localparam int ROWS     = 1 << ROW_BITS;

  logic [ROW_BITS-1:0] row_idx;
  logic [GRP_BITS-1:0] grp_idx;
  logic [COL_BITS-1:0] col_idx;
  logic [ROWS-1:0]     row_hot;
  logic [GROUPS-1:0]   grp_hot;
  logic [SUBS-1:0]     sub_bit;
  logic [LANES-1:0]    picked;

  assign row_idx = addr[AW-1:COL_BITS+GRP_BITS];
  assign grp_idx = addr[COL_BITS+GRP_BITS-1:COL_BITS];
  assign col_idx = addr[COL_BITS-1:0];
  assign row_hot = {{(ROWS-1){1'b0}}, 1'b1} << row_idx;
  assign grp_hot = {{(GROUPS-1){1'b0}}, 1'b1} << grp_idx;

  for (genvar s = 0; s < SUBS; s++) begin : g_sub
    logic [ROW_W-1:0] cells [ROWS];
    logic [ROW_W-1:0] row_word;

    always_ff @(posedge clk) begin
      for (int r = 0; r < ROWS; r++)
        if (we && grp_hot[s / LANES] && row_hot[r])
          cells[r][col_idx] <= din[s % LANES];
    end

    always_comb begin
      row_word = '0;
      for (int r = 0; r < ROWS; r++)
        row_word = row_word | (cells[r] & {ROW_W{row_hot[r]}});
    end

    assign sub_bit[s] = row_word[col_idx];
  end

  always_comb picked = sub_bit[grp_idx*LANES +: LANES];
  assign dout = oe ? picked : '0;

  AST_WRITE_READBACK: assert property (@(posedge clk) we |=> (addr != $past(addr) || !oe || dout == $past(din))) else $error("readback mismatch"); // R1
  AST_OLD_ON_WRITE: assert property (@(posedge clk) (we && oe && $past(oe) && !$past(we) && $stable(addr)) |-> $stable(dout)) else $error("write visible too early"); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) !we |=> (!$stable(addr) || !oe || !$past(oe) || $stable(dout))) else $error("contents moved without write"); // R5
  AST_OTHER_KEPT: assert property (@(posedge clk) (oe && !we) ##1 (we && addr != $past(addr)) ##1 (oe && addr == $past(addr, 2)) |-> dout == $past(dout, 2)) else $error("neighbour disturbed"); // R6
endmodule

// File: tb/test_sram_2stage.sv
module test_sram_2stage;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_BITS = 4;
  localparam int AW = ROW_BITS + 9;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic          we = 1'b0;
  logic          oe = 1'b0;
  logic [7:0]    dout;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [DEPTH];
  bit         known [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_2stage #(.ROW_BITS(ROW_BITS)) i_sram_2stage (
    .clk(clk), .addr(addr), .din(din), .we(we), .oe(oe), .dout(dout)
  );

  function automatic logic [7:0] pat(input int a, input int salt);
    return 8'((a * 29) + ((a >> 7) * 3) + salt);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%0h actual=%02h expected=%02h", req, addr, act, exp);
    end
  endtask

  task automatic step(input logic w, input int a, input logic [7:0] d, input logic o, input string req);
    we = w; addr = AW'(a); din = d; oe = o;
    @(negedge clk);
    if (!o) check(req, dout, 8'h00);
    else if (known[a]) check(req, dout, model[a]);
    @(posedge clk);
    if (w) begin model[a] = d; known[a] = 1'b1; end
    #1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) known[i] = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    // R3: output disabled from start, varied addresses
    for (int i = 0; i < 6; i++) step(1'b0, i * 1237 % DEPTH, 8'hFF, 1'b0, "R3");
    // R1 R7: fill every address
    for (int a = 0; a < DEPTH; a++) step(1'b1, a, pat(a, 5), 1'b1, "R1");
    // R7: read back whole space
    for (int a = 0; a < DEPTH; a++) step(1'b0, a, 8'h00, 1'b1, "R7");
    // R2: scattered addresses, each read in the cycle it is applied
    for (int i = 0; i < 40; i++) step(1'b0, (i * 2749 + 11) % DEPTH, 8'hA5, 1'b1, "R2");
    // R4: write with read of same address shows old byte, then new
    for (int i = 0; i < 8; i++) begin
      int a = (i * 1021 + 300) % DEPTH;
      step(1'b1, a, ~pat(a, 9), 1'b1, "R4");
      step(1'b0, a, 8'h00, 1'b1, "R4");
    end
    // R5: we low with busy din
    for (int i = 0; i < 30; i++) step(1'b0, (i * 577) % DEPTH, 8'(i * 53), 1'b1, "R5");
    // R6: neighbours in column, group, row
    for (int i = 0; i < 6; i++) begin
      int a = (i * 1531 + 700) % DEPTH;
      step(1'b1, a, 8'(i * 37 + 1), 1'b1, "R6");
      step(1'b0, a ^ 1, 8'h00, 1'b1, "R6");
      step(1'b0, a ^ 64, 8'h00, 1'b1, "R6");
      step(1'b0, a ^ (1 << 7), 8'h00, 1'b1, "R6");
      step(1'b0, a ^ (1 << 8), 8'h00, 1'b1, "R6");
      step(1'b0, a ^ (1 << 9), 8'h00, 1'b1, "R6");
      step(1'b0, a ^ (1 << (AW - 1)), 8'h00, 1'b1, "R6");
      step(1'b0, a, 8'h00, 1'b1, "R6");
    end
    // R8: extremes of the address space
    step(1'b1, 0, 8'h3C, 1'b1, "R8");
    step(1'b1, DEPTH - 1, 8'hC3, 1'b1, "R8");
    step(1'b0, 0, 8'h00, 1'b1, "R8");
    step(1'b0, DEPTH - 1, 8'h00, 1'b1, "R8");
    // R3: disabled output with known contents
    for (int i = 0; i < 10; i++) step(1'b0, (i * 811) % DEPTH, 8'h00, 1'b0, "R3");
    // R3 R1: write while output disabled, then enable
    step(1'b1, 42, 8'h99, 1'b0, "R3");
    step(1'b0, 42, 8'h00, 1'b1, "R1");
    finish_run();
  end
endmodule